// File: doc/BRIEF.md
# Memory-Backed Breakpoint Evaluator

This block watches each cycle of a target bus and looks up a breakpoint byte for the accessed address. The bytes are held in an internal array that shadows the whole address space, one byte per location. Each bit of the byte arms one kind of breakpoint. The block combines the bits with the cycle type and with the task running on the target (foreground or background). From these it reports, one clock later, a registered hit flag for each kind and a single combined break request.

A host port has three jobs. It fills breakpoint bytes over a single address or a contiguous range, using a read-modify-write under a bit mask. It programs a configuration for each kind: an enable, a task restriction and a pass count. It clears the access counters of the three general-purpose points. Each of those points has a saturating 48-bit counter of its qualifying accesses.

A range fill advances one location per clock, and only in clocks where the bus is idle. Because the number of armed locations is bounded only by the array size, a range breakpoint costs nothing beyond fill time.

Top module: `bpmem_eval`

## Requirements
- R1: Synchronous reset starts an internal pass that writes zero to every array location, one per idle bus clock. `fill_busy` is high from reset until the last location is written (4096 idle clocks at default size). After reset, all kinds are disabled, all pass counts are zero, and all outputs are zero.
- R2: Breakpoint byte bit k arms kind k. Bit 0 (code fetch) and bit 1 (source-level step) qualify only on fetch cycles. Bit 3 (data read) qualifies only on read cycles, and bit 4 (data write) only on write cycles. Bit 2 (spot) and bits 5, 6 and 7 (general-purpose A, B, C) qualify on any non-idle cycle. The `bus_cyc` encoding is 0 idle, 1 fetch, 2 read, 3 write.
- R3: `bp_hit[k]` is high in the clock after an access exactly when kind k qualified on that access. An idle cycle yields all hit flags and the break low in the next clock.
- R4: A kind qualifies only when it is enabled and its task mode admits `bus_fg`. Task mode 0 admits any task, 1 only foreground (`bus_fg`=1), 2 only background (`bus_fg`=0), and 3 none.
- R5: Fill command (`hst_cmd`=1) with `hst_lo` <= `hst_hi` rewrites every location in that range as (old & ~`hst_mask`) | (`hst_val` & `hst_mask`). It writes one location per clock with an idle bus and pauses while the bus is active. A fill with `hst_lo` > `hst_hi` does nothing, and `fill_busy` stays low.
- R6: With pass count N, the first N qualified hits of a kind do not contribute to the break. Every later hit does. A configuration command for a kind restarts its pass tally.
- R7: `bp_break` in the clock after an access is high exactly when some kind qualified on that access with its pass count already satisfied.
- R8: `gp_cnt_a`, `gp_cnt_b` and `gp_cnt_c` count qualified hits of kinds 5, 6 and 7, and they hold at all-ones.
- R9: Clear command (`hst_cmd`=3) zeroes the counters selected by `hst_mask` bits 0, 1 and 2 (A, B, C). When a clear and a qualifying access fall in the same clock, the clear wins.
- R10: Configuration command (`hst_cmd`=2) writes the settings of kind `hst_sel`. The enable comes from `hst_val[0]`, the task mode from `hst_val[2:1]` and the pass count from `hst_pass`. The new settings apply from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cyc | input | 2 | Target cycle type: 0 idle, 1 fetch, 2 read, 3 write |
| bus_addr | input | ADDR_W | Target access address |
| bus_fg | input | 1 | 1 while the foreground task runs |
| hst_cmd | input | 2 | Host command: 0 none, 1 fill, 2 configure, 3 clear counters |
| hst_sel | input | 3 | Kind selected by a configure command |
| hst_lo | input | ADDR_W | First address of a fill |
| hst_hi | input | ADDR_W | Last address of a fill |
| hst_mask | input | 8 | Fill bit mask; counter select on clear |
| hst_val | input | 8 | Fill bit values; enable and task mode on configure |
| hst_pass | input | PASS_W | Pass count on configure |
| fill_busy | output | 1 | A fill or the reset clear pass is in progress |
| bp_hit | output | 8 | Registered per-kind hit flags |
| bp_break | output | 1 | Registered combined break request |
| gp_cnt_a | output | CNT_W | Access counter of point A |
| gp_cnt_b | output | CNT_W | Access counter of point B |
| gp_cnt_c | output | CNT_W | Access counter of point C |

## Verification
A wrong array byte or a wrong fill pointer shows up at the first access that touches the affected location. The hit flag for that location is wrong in the very next clock, so a wrong address or mask is visible one clock after the access that reads it. A wrong pass tally shows up one clock after the hit where the break should first rise, or where it rises too early. A counter fault shows up as a mismatch on the counter outputs one clock after any access to a point A, B or C location. Saturation is observed through a second, narrow-counter instance fed with the same stimulus.

// File: rtl/bpe_pkg.sv
package bpe_pkg;

    localparam int NKIND = 8;
    localparam int NGP   = 3;
    localparam int GP_BASE = 5;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_FETCH = 2'd1,
        CYC_READ  = 2'd2,
        CYC_WRITE = 2'd3
    } cyc_e;

    typedef enum logic [1:0] {
        HC_NOP  = 2'd0,
        HC_FILL = 2'd1,
        HC_CFG  = 2'd2,
        HC_CLR  = 2'd3
    } hcmd_e;

    typedef enum logic [1:0] {
        TM_ANY = 2'd0,
        TM_FG  = 2'd1,
        TM_BG  = 2'd2,
        TM_OFF = 2'd3
    } tmode_e;

    typedef struct packed {
        logic       en;
        logic [1:0] tm;
    } kcfg_t;

    // which cycle types arm kind k
    function automatic logic cycle_fits(input int k, input logic [1:0] c);
        case (k)
            0, 1:    return c == CYC_FETCH;
            3:       return c == CYC_READ;
            4:       return c == CYC_WRITE;
            default: return c != CYC_IDLE;
        endcase
    endfunction

    function automatic logic task_fits(input logic [1:0] m, input logic fg);
        case (m)
            TM_ANY:  return 1'b1;
            TM_FG:   return fg;
            TM_BG:   return !fg;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/bpe_store.sv
module bpe_store #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_byte,
    input  logic              bus_idle,
    input  logic              fill_go,
    input  logic [ADDR_W-1:0] fill_lo,
    input  logic [ADDR_W-1:0] fill_hi,
    input  logic [7:0]        fill_mask,
    input  logic [7:0]        fill_val,
    output logic              busy
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0]        mem [DEPTH];
    logic              active;
    logic [ADDR_W-1:0] cur, last;
    logic [7:0]        mask_r, val_r;
    logic              wr_now;

    assign wr_now  = active && bus_idle;
    assign rd_byte = mem[rd_addr];
    assign busy    = active;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b1;
            cur    <= '0;
            last   <= '1;
            mask_r <= 8'hFF;
            val_r  <= 8'h00;
        end else if (active) begin
            if (bus_idle) begin
                if (cur == last) active <= 1'b0;
                else             cur    <= cur + 1'b1;
            end
        end else if (fill_go && (fill_lo <= fill_hi)) begin
            active <= 1'b1;
            cur    <= fill_lo;
            last   <= fill_hi;
            mask_r <= fill_mask;
            val_r  <= fill_val;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_now)
            mem[cur] <= (mem[cur] & ~mask_r) | (val_r & mask_r);
    end

    // R5: a fill never advances while the target bus is busy
    a_r5_fill_pauses: assert property (@(posedge clk) disable iff (rst)
        (active && !bus_idle) |=> (active && cur == $past(cur)));

    // R5: an inverted range never starts a fill
    a_r5_empty_range: assert property (@(posedge clk) disable iff (rst)
        (!active && fill_go && fill_lo > fill_hi) |=> !active);

endmodule

// File: rtl/bpe_qual.sv
module bpe_qual
    import bpe_pkg::*;
(
    input  logic [7:0]         bp_byte,
    input  logic [1:0]         cyc,
    input  logic               fg,
    input  kcfg_t [NKIND-1:0]  cfg,
    output logic [NKIND-1:0]   q
);
    for (genvar k = 0; k < NKIND; k++) begin : g_kind
        assign q[k] = bp_byte[k] && cfg[k].en
                      && cycle_fits(k, cyc)
                      && task_fits(cfg[k].tm, fg);
    end
endmodule

// File: rtl/bpe_pass.sv
module bpe_pass #(
    parameter int PASS_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic [PASS_W-1:0] limit,
    input  logic              hit,
    output logic              sat
);
    logic [PASS_W-1:0] passed;

    assign sat = (passed == limit);

    always_ff @(posedge clk) begin
        if (rst || restart)     passed <= '0;
        else if (hit && !sat)   passed <= passed + 1'b1;
    end

    // R6: the tally never runs past the programmed count
    a_r6_tally_bound: assert property (@(posedge clk) disable iff (rst)
        passed <= limit);

    // R6: once satisfied, a kind stays satisfied until reprogrammed
    a_r6_sat_sticks: assert property (@(posedge clk) disable iff (rst)
        (sat && !restart) |=> sat);

endmodule

// File: rtl/bpe_gpcnt.sv
module bpe_gpcnt #(
    parameter int CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr)              cnt <= '0;
        else if (inc && cnt != '1)   cnt <= cnt + 1'b1;
    end

    // R8: a full counter holds
    a_r8_saturate: assert property (@(posedge clk) disable iff (rst)
        (cnt == '1 && !clr) |=> cnt == '1);

    // R9: clear overrides any increment
    a_r9_clear_wins: assert property (@(posedge clk) disable iff (rst)
        clr |=> cnt == '0);

endmodule

// File: rtl/bpmem_eval.sv
module bpmem_eval
    import bpe_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int PASS_W = 8,
    parameter int CNT_W  = 48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        bus_cyc,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_fg,
    input  logic [1:0]        hst_cmd,
    input  logic [2:0]        hst_sel,
    input  logic [ADDR_W-1:0] hst_lo,
    input  logic [ADDR_W-1:0] hst_hi,
    input  logic [7:0]        hst_mask,
    input  logic [7:0]        hst_val,
    input  logic [PASS_W-1:0] hst_pass,
    output logic              fill_busy,
    output logic [7:0]        bp_hit,
    output logic              bp_break,
    output logic [CNT_W-1:0]  gp_cnt_a,
    output logic [CNT_W-1:0]  gp_cnt_b,
    output logic [CNT_W-1:0]  gp_cnt_c
);
    logic              bus_idle;
    logic [7:0]        cur_byte;
    kcfg_t [NKIND-1:0] cfg_r;
    logic [PASS_W-1:0] lim_r [NKIND];
    logic [NKIND-1:0]  qual, sat;
    logic [CNT_W-1:0]  gp_cnt [NGP];
    logic              is_cfg, is_clr;

    assign bus_idle = (bus_cyc == CYC_IDLE);
    assign is_cfg   = (hst_cmd == HC_CFG);
    assign is_clr   = (hst_cmd == HC_CLR);

    bpe_store #(.ADDR_W(ADDR_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .rd_addr  (bus_addr),
        .rd_byte  (cur_byte),
        .bus_idle (bus_idle),
        .fill_go  (hst_cmd == HC_FILL),
        .fill_lo  (hst_lo),
        .fill_hi  (hst_hi),
        .fill_mask(hst_mask),
        .fill_val (hst_val),
        .busy     (fill_busy)
    );

    bpe_qual u_qual (
        .bp_byte(cur_byte),
        .cyc    (bus_cyc),
        .fg     (bus_fg),
        .cfg    (cfg_r),
        .q      (qual)
    );

    // per-kind configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_r <= '0;
            for (int k = 0; k < NKIND; k++) lim_r[k] <= '0;
        end else if (is_cfg) begin
            cfg_r[hst_sel].en <= hst_val[0];
            cfg_r[hst_sel].tm <= hst_val[2:1];
            lim_r[hst_sel]    <= hst_pass;
        end
    end

    for (genvar k = 0; k < NKIND; k++) begin : g_pass
        bpe_pass #(.PASS_W(PASS_W)) u_pass (
            .clk    (clk),
            .rst    (rst),
            .restart(is_cfg && hst_sel == 3'(k)),
            .limit  (lim_r[k]),
            .hit    (qual[k]),
            .sat    (sat[k])
        );
    end

    for (genvar i = 0; i < NGP; i++) begin : g_gp
        bpe_gpcnt #(.CNT_W(CNT_W)) u_cnt (
            .clk(clk),
            .rst(rst),
            .clr(is_clr && hst_mask[i]),
            .inc(qual[GP_BASE + i]),
            .cnt(gp_cnt[i])
        );
    end

    assign gp_cnt_a = gp_cnt[0];
    assign gp_cnt_b = gp_cnt[1];
    assign gp_cnt_c = gp_cnt[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            bp_hit   <= '0;
            bp_break <= 1'b0;
        end else begin
            bp_hit   <= qual;
            bp_break <= |(qual & sat);
        end
    end

    // R2: code-fetch and source-step kinds only on fetch cycles
    a_r2_fetch_kinds: assert property (@(posedge clk) disable iff (rst)
        (bp_hit[0] || bp_hit[1]) |-> $past(bus_cyc) == CYC_FETCH);

    // R2: data kinds follow the direction of the access
    a_r2_read_kind: assert property (@(posedge clk) disable iff (rst)
        bp_hit[3] |-> $past(bus_cyc) == CYC_READ);
    a_r2_write_kind: assert property (@(posedge clk) disable iff (rst)
        bp_hit[4] |-> $past(bus_cyc) == CYC_WRITE);

    // R3: an idle cycle produces nothing
    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        bus_idle |=> (bp_hit == '0 && !bp_break));

    // R7: a break always comes with at least one hit flag
    a_r7_break_has_hit: assert property (@(posedge clk) disable iff (rst)
        bp_break |-> bp_hit != '0);

endmodule

// File: tb/bpmem_eval_tb.sv
module bpmem_eval_tb;
    localparam int AW = 12;
    localparam int PW = 8;
    localparam int CW = 48;
    localparam int SW = 3;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    bus_cyc = 2'd0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_fg = 1'b0;
    logic [1:0]    hst_cmd = 2'd0;
    logic [2:0]    hst_sel = '0;
    logic [AW-1:0] hst_lo = '0, hst_hi = '0;
    logic [7:0]    hst_mask = '0, hst_val = '0;
    logic [PW-1:0] hst_pass = '0;
    logic          fill_busy, fill_busy_s;
    logic [7:0]    bp_hit, bp_hit_s;
    logic          bp_break, bp_break_s;
    logic [CW-1:0] ca, cb, cc;
    logic [SW-1:0] sa, sb, sc;

    always #5 clk = ~clk;

    bpmem_eval #(.ADDR_W(AW), .PASS_W(PW), .CNT_W(CW)) u_dut (
        .clk, .rst, .bus_cyc, .bus_addr, .bus_fg, .hst_cmd, .hst_sel,
        .hst_lo, .hst_hi, .hst_mask, .hst_val, .hst_pass,
        .fill_busy, .bp_hit, .bp_break,
        .gp_cnt_a(ca), .gp_cnt_b(cb), .gp_cnt_c(cc));

    bpmem_eval #(.ADDR_W(AW), .PASS_W(PW), .CNT_W(SW)) u_dut_small (
        .clk, .rst, .bus_cyc, .bus_addr, .bus_fg, .hst_cmd, .hst_sel,
        .hst_lo, .hst_hi, .hst_mask, .hst_val, .hst_pass,
        .fill_busy(fill_busy_s), .bp_hit(bp_hit_s), .bp_break(bp_break_s),
        .gp_cnt_a(sa), .gp_cnt_b(sb), .gp_cnt_c(sc));

    // bench model
    logic [7:0]     m_mem [DEPTH];
    logic           m_en [8];
    logic [1:0]     m_tm [8];
    int             m_lim [8];
    int             m_pas [8];
    longint         m_cnt [3];
    int             total = 0, bad = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic m_cyc_ok(input int k, input logic [1:0] c);
        if (k == 0 || k == 1) return c == 2'd1;
        if (k == 3)           return c == 2'd2;
        if (k == 4)           return c == 2'd3;
        return c != 2'd0;
    endfunction

    function automatic logic m_task_ok(input logic [1:0] m, input logic fg);
        if (m == 2'd0) return 1'b1;
        if (m == 2'd1) return fg;
        if (m == 2'd2) return !fg;
        return 1'b0;
    endfunction

    function automatic longint m_small(input longint v);
        return (v > 7) ? 7 : v;
    endfunction

    task automatic chk_counters(input string tag);
        chk({tag, " R8 cnt a"}, 64'(ca), 64'(m_cnt[0]));
        chk({tag, " R8 cnt b"}, 64'(cb), 64'(m_cnt[1]));
        chk({tag, " R8 cnt c"}, 64'(cc), 64'(m_cnt[2]));
        chk({tag, " R8 sat a"}, 64'(sa), 64'(m_small(m_cnt[0])));
        chk({tag, " R8 sat c"}, 64'(sc), 64'(m_small(m_cnt[2])));
    endtask

    // predicts one access; returns qualified vector and break
    task automatic predict(input logic [1:0] c, input int a, input logic fg,
                           output logic [7:0] q, output logic brk);
        logic [7:0] b;
        b = m_mem[a];
        brk = 1'b0;
        for (int k = 0; k < 8; k++) begin
            q[k] = b[k] && m_en[k] && m_cyc_ok(k, c) && m_task_ok(m_tm[k], fg);
            if (q[k]) begin
                if (m_pas[k] == m_lim[k]) brk = 1'b1;
                else                      m_pas[k]++;
            end
        end
        for (int i = 0; i < 3; i++) if (q[5+i]) m_cnt[i]++;
    endtask

    task automatic access(input logic [1:0] c, input int a, input logic fg);
        logic [7:0] q;
        logic brk;
        bus_cyc = c; bus_addr = AW'(a); bus_fg = fg;
        predict(c, a, fg, q, brk);
        @(negedge clk);
        chk("R2 R3 R4 hit flags", 64'(bp_hit), 64'(q));
        chk("R6 R7 break", 64'(bp_break), 64'(brk));
        chk_counters("access");
        bus_cyc = 2'd0;
    endtask

    task automatic host(input logic [1:0] cmd, input int sel, input int lo, input int hi,
                        input logic [7:0] mask, input logic [7:0] val, input int pass);
        hst_cmd = cmd; hst_sel = 3'(sel); hst_lo = AW'(lo); hst_hi = AW'(hi);
        hst_mask = mask; hst_val = val; hst_pass = PW'(pass);
        if (cmd == 2'd2) begin
            m_en[sel] = val[0]; m_tm[sel] = val[2:1]; m_lim[sel] = pass; m_pas[sel] = 0;
        end
        if (cmd == 2'd3)
            for (int i = 0; i < 3; i++) if (mask[i]) m_cnt[i] = 0;
        @(negedge clk);
        hst_cmd = 2'd0;
    endtask

    task automatic cfg(input int sel, input logic en, input logic [1:0] tm, input int pass);
        host(2'd2, sel, 0, 0, 8'h00, {5'd0, tm, en}, pass);
    endtask

    task automatic fill(input int lo, input int hi, input logic [7:0] mask, input logic [7:0] val);
        host(2'd1, 0, lo, hi, mask, val, 0);
        while (fill_busy) @(negedge clk);
        if (lo <= hi)
            for (int a = lo; a <= hi; a++) m_mem[a] = (m_mem[a] & ~mask) | (val & mask);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int n;
        logic [7:0] q;
        logic brk;
        void'($urandom(32'd20240611));
        for (int a = 0; a < DEPTH; a++) m_mem[a] = 8'h00;
        for (int k = 0; k < 8; k++) begin m_en[k] = 0; m_tm[k] = 0; m_lim[k] = 0; m_pas[k] = 0; end
        for (int i = 0; i < 3; i++) m_cnt[i] = 0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 busy after reset", 64'(fill_busy), 64'd1);
        chk("R1 hits after reset", 64'(bp_hit), 64'd0);
        chk("R1 break after reset", 64'(bp_break), 64'd0);
        chk_counters("R1 reset");
        n = 0;
        while (fill_busy) begin @(negedge clk); n++; end
        chk("R1 clear pass length", 64'(n), 64'(DEPTH));

        // R1: kinds start disabled even on armed bytes
        fill(10, 10, 8'hFF, 8'hFF);
        access(2'd1, 10, 1'b1);

        // R10 configure: enable all kinds, any task, no pass
        for (int k = 0; k < 8; k++) cfg(k, 1'b1, 2'd0, 0);
        access(2'd1, 10, 1'b1);
        access(2'd2, 10, 1'b0);
        access(2'd3, 10, 1'b1);
        access(2'd0, 10, 1'b1);

        // R6: pass count of two on spot kind
        fill(7, 7, 8'hFF, 8'h04);
        cfg(2, 1'b1, 2'd0, 2);
        for (int j = 0; j < 4; j++) access(2'd2, 7, 1'b0);

        // R4: point B only in the foreground
        fill(20, 22, 8'h40, 8'h40);
        cfg(6, 1'b1, 2'd1, 0);
        access(2'd2, 21, 1'b0);
        access(2'd2, 21, 1'b1);
        cfg(6, 1'b1, 2'd3, 0);
        access(2'd2, 22, 1'b1);

        // R5 fill pauses while the bus is active
        host(2'd1, 0, 100, 103, 8'hFF, 8'h20, 0);
        for (int j = 0; j < 6; j++) begin
            access(2'd2, 0, 1'b0);
            chk("R5 busy during bus activity", 64'(fill_busy), 64'd1);
        end
        repeat (3) @(negedge clk);
        chk("R5 busy before last write", 64'(fill_busy), 64'd1);
        @(negedge clk);
        chk("R5 busy after last write", 64'(fill_busy), 64'd0);
        for (int a = 100; a <= 103; a++) m_mem[a] = 8'h20;
        access(2'd3, 103, 1'b0);
        access(2'd3, 104, 1'b0);

        // R5 inverted range is a no-op
        host(2'd1, 0, 200, 199, 8'hFF, 8'hFF, 0);
        chk("R5 inverted range busy", 64'(fill_busy), 64'd0);
        access(2'd2, 200, 1'b0);
        access(2'd2, 199, 1'b0);

        // R9 clear coincides with a qualifying access on point A
        cfg(5, 1'b1, 2'd0, 0);
        hst_cmd = 2'd3; hst_mask = 8'h01;
        bus_cyc = 2'd2; bus_addr = AW'(101); bus_fg = 1'b0;
        predict(2'd2, 101, 1'b0, q, brk);
        m_cnt[0] = 0;
        @(negedge clk);
        hst_cmd = 2'd0; bus_cyc = 2'd0;
        chk("R9 clear wins hit", 64'(bp_hit), 64'(q));
        chk("R9 clear wins count", 64'(ca), 64'd0);

        // R8 saturation of the narrow instance
        for (int j = 0; j < 10; j++) access(2'd1, 102, 1'b1);

        // random mix
        for (int it = 0; it < 500; it++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 8) begin
                cfg($urandom_range(0, 7), 1'($urandom_range(0, 3) != 0),
                    2'($urandom_range(0, 3)), $urandom_range(0, 3));
            end else if (r < 16) begin
                int lo, hi;
                lo = $urandom_range(0, 63);
                hi = lo + $urandom_range(0, 7) - 1;
                fill(lo, hi, 8'($urandom), 8'($urandom));
            end else if (r < 19) begin
                host(2'd3, 0, 0, 0, 8'($urandom_range(0, 7)), 8'h00, 0);
                chk_counters("R9 random clear");
            end else begin
                access(2'($urandom_range(0, 3)), $urandom_range(0, 70), 1'($urandom_range(0, 1)));
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule